// File: doc/BRIEF.md
# Triggered Multichannel Conversion Sequencer

This block drives an external analog-to-digital converter core through a start/done handshake. On a trigger from the selected source it runs one sweep over a set of channel slots. Each slot can be enabled on its own. The slots are visited either in ascending index order or in an order that software supplies as a list of channel numbers. Before each conversion the block waits out a programmable tracking delay. When the core reports completion, the sample goes into a last-result register, tagged with its channel, and into that channel's own result register. A per-channel ready flag is raised at the same time.

Four trigger sources exist: a software start, a rising edge on an asynchronous external pin, a rising edge on a timer output, and a rising edge on a PWM event line. In sleep mode the core is powered only from an accepted trigger until the last enabled channel of the sweep has been converted. After each wake a startup delay runs before the first tracking delay. A trigger that arrives while a sweep is running is dropped and sets an overrun flag. Configuration inputs are expected to be held stable while a sweep is running.

Top module: `conv_sequencer`

## Requirements
- R1: Only channels whose `chan_en` bit is 1 are converted; `adc_chan` carries the channel number whenever `adc_start` is high.
- R2: With `use_list` = 0 a sweep converts the enabled channels in ascending channel number.
- R3: With `use_list` = 1, position p of the sweep names channel `seq_list[4p+3:4p]`. Positions are walked from 0 to 15, and a position is converted only when the channel it names is enabled.
- R4: `trig_sel` picks the only source that can start a sweep: 0 software (`sw_start` high at a clock edge), 1 external pin, 2 timer output, 3 PWM event. Activity on the other sources starts nothing.
- R5: The external pin passes through a two-stage synchroniser. Only its rising edge triggers, so holding it high starts exactly one sweep.
- R6: A finished conversion writes the sample to `last_data`, the channel to `last_chan`, and the sample to that channel's register, which reads back on `rd_data` when `rd_chan` selects it.
- R7: `data_rdy[c]` sets when channel c's result is written and clears at the clock edge where `rd_en` is high with `rd_chan` = c.
- R8: With the core awake (`sleep_en` = 0), a trigger accepted at edge 0 gives `adc_start` high after edge `track_cyc`+1.
- R9: With `sleep_en` = 1, `core_pwr` is low while idle and high for the whole sweep. The first `adc_start` follows edge `startup_cyc`+`track_cyc`+2 after the accepting edge. `core_pwr` drops when the sweep ends.
- R10: A trigger while `busy` is high is ignored and sets `overrun`. `overrun` clears when the next trigger is accepted.
- R11: If no channel is enabled, a trigger causes no conversion and `busy` stays low.
- R12: `adc_start` is a one-cycle pulse, and no new start is issued before `adc_done` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 2 | Trigger source select (0 soft, 1 pin, 2 timer, 3 PWM) |
| sw_start | input | 1 | Software start |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| tmr_trig | input | 1 | Timer output |
| pwm_trig | input | 1 | PWM event line |
| chan_en | input | 16 | Per-channel enable |
| use_list | input | 1 | 1: use seq_list order, 0: ascending order |
| seq_list | input | 64 | Channel number for each of 16 sweep positions, 4 bits each |
| sleep_en | input | 1 | Power the core only during sweeps |
| startup_cyc | input | 8 | Startup delay after wake |
| track_cyc | input | 8 | Tracking delay before each start |
| adc_start | output | 1 | Start-of-conversion pulse to the core |
| adc_chan | output | 4 | Channel to convert |
| adc_done | input | 1 | Core reports a finished conversion |
| adc_data | input | 12 | Sample from the core, valid with adc_done |
| core_pwr | output | 1 | Core power enable |
| busy | output | 1 | Sweep in progress |
| overrun | output | 1 | A trigger was dropped during a sweep |
| last_data | output | 12 | Most recent sample |
| last_chan | output | 4 | Channel of the most recent sample |
| data_rdy | output | 16 | Per-channel ready flags |
| rd_en | input | 1 | Read strobe, clears the selected channel's flag |
| rd_chan | input | 4 | Channel selected for reading |
| rd_data | output | 12 | Result register of the selected channel |

## Verification
The sweep is tried with four enable/order combinations: every channel in ascending order, a sparse enable mask in ascending order, a mask under a reversed list, and a mask under a strided list whose positions name disabled channels. Together these separate a design that walks channels from one that walks list positions. They also show whether the enable is applied to the named channel or to the position. Each sample carries its channel and a sweep number, so a write to the wrong register or a stale flag stands out. Directed runs then measure the start latency awake and asleep, and probe each trigger source against the other three. They also hold the pin high, fire a trigger mid-sweep, and fire one with nothing enabled.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [1:0] {
      TRG_SOFT = 2'd0,
      TRG_PIN  = 2'd1,
      TRG_TMR  = 2'd2,
      TRG_PWM  = 2'd3
   } trig_src_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_TRACK,
      ST_START,
      ST_WAIT
   } seq_state_e;
endpackage

// File: rtl/seq_trig_front.sv
module seq_trig_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       sw_start,
   input  logic       ext_pin,
   input  logic       tmr_evt,
   input  logic       pwm_evt,
   output logic       trig
);
   import seq_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("seq_trig_front: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic pin_prev, tmr_prev, pwm_prev;
   logic pin_rise, tmr_rise, pwm_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q   <= '0;
         pin_prev <= 1'b0;
         tmr_prev <= 1'b0;
         pwm_prev <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_pin};
         pin_prev <= sync_q[SYNC_STAGES-1];
         tmr_prev <= tmr_evt;
         pwm_prev <= pwm_evt;
      end
   end

   assign pin_rise = sync_q[SYNC_STAGES-1] & ~pin_prev;
   assign tmr_rise = tmr_evt & ~tmr_prev;
   assign pwm_rise = pwm_evt & ~pwm_prev;

   always_comb begin
      unique case (trig_src_e'(sel))
         TRG_SOFT: trig = sw_start;
         TRG_PIN:  trig = pin_rise;
         TRG_TMR:  trig = tmr_rise;
         TRG_PWM:  trig = pwm_rise;
         default:  trig = 1'b0;
      endcase
   end

   // a synchronised pin edge lasts one cycle only
   assert_pin_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);
endmodule

// File: rtl/seq_order.sv
module seq_order #(
   parameter int NCH = 16,
   localparam int CW = $clog2(NCH)
) (
   input  logic [NCH-1:0]    chan_en,
   input  logic              use_list,
   input  logic [NCH*CW-1:0] seq_list,
   input  logic [CW-1:0]     cur_pos,
   input  logic              from_start,
   output logic [CW-1:0]     cur_ch,
   output logic [CW-1:0]     nxt_pos,
   output logic              nxt_ok
);
   logic [CW-1:0]  pos_map [NCH];
   logic [NCH-1:0] pos_ok;
   logic [NCH-1:0] cand;

   for (genvar p = 0; p < NCH; p++) begin : g_pos
      localparam logic [CW-1:0] PV = CW'(p);
      assign pos_map[p] = use_list ? seq_list[p*CW +: CW] : PV;
      assign pos_ok[p]  = chan_en[pos_map[p]];
      assign cand[p]    = pos_ok[p] & (from_start | (PV > cur_pos));
   end

   assign cur_ch = pos_map[cur_pos];
   assign nxt_ok = |cand;

   always_comb begin
      nxt_pos = '0;
      for (int p = NCH - 1; p >= 0; p--) begin
         if (cand[p]) nxt_pos = CW'(p);
      end
   end
endmodule

// File: rtl/seq_result_bank.sv
module seq_result_bank #(
   parameter int NCH = 16,
   parameter int DW  = 12,
   localparam int CW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [CW-1:0]  wr_ch,
   input  logic [DW-1:0]  wr_data,
   input  logic           rd_en,
   input  logic [CW-1:0]  rd_ch,
   output logic [DW-1:0]  rd_data,
   output logic [NCH-1:0] rdy
);
   logic [DW-1:0]  res_q [NCH];
   logic [NCH-1:0] rdy_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic [CW-1:0] CV = CW'(c);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q[c] <= '0;
            rdy_q[c] <= 1'b0;
         end else if (we && wr_ch == CV) begin
            res_q[c] <= wr_data;
            rdy_q[c] <= 1'b1;
         end else if (rd_en && rd_ch == CV) begin
            rdy_q[c] <= 1'b0;
         end
      end

      assert_rdy_set_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wr_ch == CV) |=> rdy_q[c]);
      assert_rdy_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && rd_ch == CV && !(we && wr_ch == CV)) |=> !rdy_q[c]);
   end

   assign rd_data = res_q[rd_ch];
   assign rdy     = rdy_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int NCH         = 16,
   parameter int DW          = 12,
   parameter int TW          = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        trig_sel,
   input  logic              sw_start,
   input  logic              ext_trig,
   input  logic              tmr_trig,
   input  logic              pwm_trig,
   input  logic [NCH-1:0]    chan_en,
   input  logic              use_list,
   input  logic [NCH*CW-1:0] seq_list,
   input  logic              sleep_en,
   input  logic [TW-1:0]     startup_cyc,
   input  logic [TW-1:0]     track_cyc,
   output logic              adc_start,
   output logic [CW-1:0]     adc_chan,
   input  logic              adc_done,
   input  logic [DW-1:0]     adc_data,
   output logic              core_pwr,
   output logic              busy,
   output logic              overrun,
   output logic [DW-1:0]     last_data,
   output logic [CW-1:0]     last_chan,
   output logic [NCH-1:0]    data_rdy,
   input  logic              rd_en,
   input  logic [CW-1:0]     rd_chan,
   output logic [DW-1:0]     rd_data
);
   import seq_pkg::*;

   if (NCH < 2 || NCH > 64 || (1 << CW) != NCH) begin : g_bad_nch
      $error("conv_sequencer: NCH must be a power of two from 2 to 64");
   end
   if (DW < 1 || TW < 1) begin : g_bad_width
      $error("conv_sequencer: DW and TW must be positive");
   end

   seq_state_e    state_q;
   logic [TW-1:0] cnt_q;
   logic [CW-1:0] pos_q;
   logic          ovr_q;
   logic          trig;
   logic [CW-1:0] cur_ch, nxt_pos;
   logic          nxt_ok, from_start, wr_en;

   seq_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (trig_sel),
      .sw_start (sw_start),
      .ext_pin  (ext_trig),
      .tmr_evt  (tmr_trig),
      .pwm_evt  (pwm_trig),
      .trig     (trig)
   );

   assign from_start = (state_q == ST_IDLE);

   seq_order #(.NCH(NCH)) u_order (
      .chan_en    (chan_en),
      .use_list   (use_list),
      .seq_list   (seq_list),
      .cur_pos    (pos_q),
      .from_start (from_start),
      .cur_ch     (cur_ch),
      .nxt_pos    (nxt_pos),
      .nxt_ok     (nxt_ok)
   );

   assign wr_en = (state_q == ST_WAIT) && adc_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         pos_q   <= '0;
         ovr_q   <= 1'b0;
      end else begin
         if (trig && state_q != ST_IDLE) ovr_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (trig) ovr_q <= 1'b0;
               if (trig && nxt_ok) begin
                  pos_q <= nxt_pos;
                  if (sleep_en) begin
                     state_q <= ST_WAKE;
                     cnt_q   <= startup_cyc;
                  end else begin
                     state_q <= ST_TRACK;
                     cnt_q   <= track_cyc;
                  end
               end
            end
            ST_WAKE: begin
               if (cnt_q == '0) begin
                  state_q <= ST_TRACK;
                  cnt_q   <= track_cyc;
               end else begin
                  cnt_q <= cnt_q - TW'(1);
               end
            end
            ST_TRACK: begin
               if (cnt_q == '0) state_q <= ST_START;
               else cnt_q <= cnt_q - TW'(1);
            end
            ST_START: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (adc_done) begin
                  if (nxt_ok) begin
                     pos_q   <= nxt_pos;
                     state_q <= ST_TRACK;
                     cnt_q   <= track_cyc;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_data <= '0;
         last_chan <= '0;
      end else if (wr_en) begin
         last_data <= adc_data;
         last_chan <= cur_ch;
      end
   end

   seq_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .wr_ch   (cur_ch),
      .wr_data (adc_data),
      .rd_en   (rd_en),
      .rd_ch   (rd_chan),
      .rd_data (rd_data),
      .rdy     (data_rdy)
   );

   assign adc_start = (state_q == ST_START);
   assign adc_chan  = cur_ch;
   assign busy      = (state_q != ST_IDLE);
   assign core_pwr  = !sleep_en || (state_q != ST_IDLE);
   assign overrun   = ovr_q;

   assert_start_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> chan_en[adc_chan]);
   assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);
   assert_start_powered_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> core_pwr);
   assert_drop_sets_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy) |=> overrun);
   assert_empty_mask_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig && chan_en == '0) |=> !busy);
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
   localparam int NCH = 16;
   localparam int DW  = 12;
   localparam int TW  = 8;
   localparam int CW  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic sw_start = 0, ext_trig = 0, tmr_trig = 0, pwm_trig = 0;
   logic [NCH-1:0] chan_en = '0;
   logic use_list = 0;
   logic [NCH*CW-1:0] seq_list = '0;
   logic sleep_en = 0;
   logic [TW-1:0] startup_cyc = 8'd0, track_cyc = 8'd2;
   logic adc_start, adc_done;
   logic [CW-1:0] adc_chan;
   logic [DW-1:0] adc_data;
   logic core_pwr, busy, overrun;
   logic [DW-1:0] last_data, rd_data;
   logic [CW-1:0] last_chan;
   logic [NCH-1:0] data_rdy;
   logic rd_en = 0;
   logic [CW-1:0] rd_chan = '0;

   always #10 clk = ~clk;

   conv_sequencer dut (
      .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .sw_start(sw_start),
      .ext_trig(ext_trig), .tmr_trig(tmr_trig), .pwm_trig(pwm_trig),
      .chan_en(chan_en), .use_list(use_list), .seq_list(seq_list),
      .sleep_en(sleep_en), .startup_cyc(startup_cyc), .track_cyc(track_cyc),
      .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
      .adc_data(adc_data), .core_pwr(core_pwr), .busy(busy), .overrun(overrun),
      .last_data(last_data), .last_chan(last_chan), .data_rdy(data_rdy),
      .rd_en(rd_en), .rd_chan(rd_chan), .rd_data(rd_data)
   );

   // converter core model: done three cycles after a start, sample = {channel, sweep number}
   logic [7:0] sweep_no = 8'd0;
   logic [CW-1:0] lat_ch = '0;
   logic [2:0] dcnt = 3'd0;
   logic [CW-1:0] log_ch [256];
   int log_n = 0;
   initial begin adc_done = 1'b0; adc_data = '0; end
   always @(posedge clk) begin
      if (adc_start) begin
         lat_ch <= adc_chan;
         dcnt   <= 3'd3;
         log_ch[log_n & 255] <= adc_chan;
         log_n  <= log_n + 1;
      end else if (dcnt != 0) begin
         dcnt <= dcnt - 3'd1;
      end
      adc_done <= (dcnt == 3'd1);
      adc_data <= {lat_ch, sweep_no};
   end

   int total = 0, fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [NCH*CW-1:0] make_list(input int mode);
      logic [NCH*CW-1:0] l = '0;
      for (int p = 0; p < NCH; p++) begin
         if (mode == 1) l[p*CW +: CW] = CW'(NCH - 1 - p);
         else if (mode == 2) l[p*CW +: CW] = CW'((p * 5 + 3) % NCH);
         else l[p*CW +: CW] = CW'(p);
      end
      return l;
   endfunction

   task automatic pulse_sw();
      @(negedge clk) sw_start = 1;
      @(negedge clk) sw_start = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic measure_start(output int n);
      n = 0;
      @(negedge clk) sw_start = 1;
      while (n < 1000) begin
         @(posedge clk);
         n++;
         #1;
         sw_start = 0;
         if (adc_start) break;
      end
   endtask

   // {mode, enable mask}: mode 0 ascending, 1 reversed list, 2 strided list
   localparam logic [17:0] VEC [4] = '{
      {2'd0, 16'hFFFF},
      {2'd0, 16'h8421},
      {2'd1, 16'hA5A5},
      {2'd2, 16'h0F3C}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++; total++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      sleep_en = 1;
      repeat (3) @(negedge clk);
      // reset state
      chk(busy == 0 && overrun == 0 && data_rdy == 0, "reset", int'(busy), 0);
      chk(core_pwr == 0, "R9 reset power", int'(core_pwr), 0);
      rst_n = 1;
      sleep_en = 0;
      repeat (3) @(negedge clk);

      // table walk: R1 R2 R3 R6 R7
      for (int i = 0; i < 4; i++) begin
         int base, ecnt, mode;
         logic [CW-1:0] exp_ch [NCH];
         logic [NCH*CW-1:0] lst;
         mode = int'(VEC[i][17:16]);
         lst = make_list(mode);
         ecnt = 0;
         for (int p = 0; p < NCH; p++) begin
            logic [CW-1:0] ch;
            ch = (mode == 0) ? CW'(p) : lst[p*CW +: CW];
            if (VEC[i][ch]) begin exp_ch[ecnt] = ch; ecnt++; end
         end
         @(negedge clk);
         chan_en  = VEC[i][15:0];
         use_list = (mode != 0);
         seq_list = lst;
         sweep_no = 8'(i + 1);
         base = log_n;
         pulse_sw();
         wait_idle();
         chk(log_n - base == ecnt, "R1 conversion count", log_n - base, ecnt);
         for (int k = 0; k < ecnt && k < log_n - base; k++)
            chk(log_ch[(base + k) & 255] == exp_ch[k], mode == 0 ? "R2 order" : "R3 order",
                int'(log_ch[(base + k) & 255]), int'(exp_ch[k]));
         chk(last_chan == exp_ch[ecnt-1], "R6 last channel", int'(last_chan), int'(exp_ch[ecnt-1]));
         chk(last_data == {exp_ch[ecnt-1], sweep_no}, "R6 last data", int'(last_data),
             int'({exp_ch[ecnt-1], sweep_no}));
         for (int c = 0; c < NCH; c++) begin
            @(negedge clk) rd_chan = CW'(c);
            #1;
            if (VEC[i][c]) begin
               chk(data_rdy[c] == 1, "R7 ready set", int'(data_rdy[c]), 1);
               chk(rd_data == {CW'(c), sweep_no}, "R6 channel register", int'(rd_data),
                   int'({CW'(c), sweep_no}));
               rd_en = 1;
               @(negedge clk) rd_en = 0;
               chk(data_rdy[c] == 0, "R7 ready cleared by read", int'(data_rdy[c]), 0);
            end else begin
               chk(data_rdy[c] == 0, "R1 disabled channel untouched", int'(data_rdy[c]), 0);
            end
         end
      end

      // R8: start latency with core awake
      begin
         int n;
         use_list = 0; chan_en = 16'h0010; track_cyc = 8'd4; sleep_en = 0;
         measure_start(n);
         chk(n == 6, "R8 start latency", n, 6);
         wait_idle();
      end

      // R9: sleep mode power and startup delay
      begin
         int n;
         sleep_en = 1; startup_cyc = 8'd5; track_cyc = 8'd1;
         @(negedge clk);
         chk(core_pwr == 0, "R9 asleep while idle", int'(core_pwr), 0);
         measure_start(n);
         chk(n == 9, "R9 wake latency", n, 9);
         chk(core_pwr == 1, "R9 awake in sweep", int'(core_pwr), 1);
         wait_idle();
         chk(core_pwr == 0, "R9 asleep after sweep", int'(core_pwr), 0);
         sleep_en = 0; track_cyc = 8'd2;
      end

      // R4: only the selected source triggers
      begin
         int base;
         trig_sel = 2'd2;
         base = log_n;
         pulse_sw();
         @(negedge clk) pwm_trig = 1;
         @(negedge clk) pwm_trig = 0;
         @(negedge clk) ext_trig = 1;
         repeat (5) @(negedge clk);
         ext_trig = 0;
         repeat (5) @(negedge clk);
         chk(busy == 0 && log_n == base, "R4 other sources ignored", log_n - base, 0);
         tmr_trig = 1;
         @(negedge clk) tmr_trig = 0;
         chk(busy == 1, "R4 timer accepted", int'(busy), 1);
         wait_idle();
         chk(log_n - base == 1, "R4 timer sweep", log_n - base, 1);
      end

      // R5: held pin starts exactly one sweep
      begin
         int base;
         trig_sel = 2'd1;
         base = log_n;
         @(negedge clk) ext_trig = 1;
         repeat (40) @(negedge clk);
         ext_trig = 0;
         repeat (10) @(negedge clk);
         chk(log_n - base == 1, "R5 single sweep per edge", log_n - base, 1);
         trig_sel = 2'd0;
      end

      // R10: trigger during sweep dropped, overrun set then cleared
      begin
         int base;
         base = log_n;
         pulse_sw();
         repeat (2) @(negedge clk);
         pulse_sw();
         chk(overrun == 1, "R10 overrun set", int'(overrun), 1);
         wait_idle();
         chk(log_n - base == 1, "R10 dropped trigger", log_n - base, 1);
         pulse_sw();
         chk(overrun == 0, "R10 overrun cleared", int'(overrun), 0);
         wait_idle();
      end

      // R11: nothing enabled
      begin
         int base;
         chan_en = '0;
         base = log_n;
         pulse_sw();
         chk(busy == 0, "R11 stays idle", int'(busy), 0);
         repeat (10) @(negedge clk);
         chk(log_n == base, "R11 no conversion", log_n - base, 0);
      end

      // R12: one pulse per conversion
      begin
         int pulses;
         chan_en = 16'h0003; pulses = 0;
         @(negedge clk) sw_start = 1;
         @(negedge clk) sw_start = 0;
         while (busy) begin
            if (adc_start) pulses++;
            @(negedge clk);
         end
         chk(pulses == 2, "R12 start pulses", pulses, 2);
      end

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule